// File: doc/BRIEF.md
# SPI flash micro-op sequencer

This block drives a serial flash device by running a queue of small operations. Software or a host controller pushes 14-bit operation words into an operation FIFO. It also pushes the bytes to send into a write-data FIFO. The engine pops each word and carries out the operation on the SCK, chip-select and two data lines. Bytes received from the flash land in a read-data FIFO that the host drains.

An operation word can do one of several things. It can raise or lower chip select, or run idle clock periods. It can shift bytes out or in on one or two lines. A turnaround operation sends the final command or address byte and then releases the data lines so the flash can answer. A complete flash command is a short list of these words, for example: select, send opcode and address, turn around, read N bytes, deselect, idle clocks.

When the engine needs a byte that has not arrived, or must store a byte where there is no room, it pauses with SCK low and resumes where it stopped. Six sticky interrupt flags record overflow and underflow conditions. Each flag has its own enable bit.

Top module: `spi_uop_seq`

## Requirements
- R1: An operation word holds the opcode in bits 13:9 and a repeat count in bits 8:0, and words run in push order. Opcode 0x01 drives cs_no low. Opcode 0x00 drives cs_no high and releases both data lines (io_oe_o = 00). Chip select changes only while SCK is low.
- R2: After reset, cs_no is high, sck_o is low, io_oe_o is 00, all interrupt flags are 0 and all three FIFOs report empty.
- R3: The interface uses SPI mode 0: SCK idles low, the inputs are sampled when SCK rises, and io_o and io_oe_o change only while SCK is low.
- R4: Opcode 0x08 sends count bytes from the write FIFO, in FIFO order and most significant bit first, on IO0 (io_oe_o = 01). The lines stay driven after the operation ends.
- R5: Opcode 0x09 sends bytes two bits per clock, with the higher bit of each pair on IO1, using 4 clocks per byte and io_oe_o = 11. The lines stay driven after the operation ends. io_oe_o never takes the value 10.
- R6: Opcode 0x0C receives count bytes into the read FIFO, most significant bit first, taking one bit from IO1 at each rising edge with io_oe_o = 00.
- R7: Opcode 0x0E receives two bits per rising edge from IO1 and IO0 (IO1 holds the higher bit), using 4 clocks per byte.
- R8: The turnaround opcodes send bytes and then release both lines (io_oe_o = 00) at the end of the operation. Opcode 0x10 sends on one line and precedes single-line input. Opcode 0x11 sends on one line and precedes dual input. Opcode 0x14 sends on two lines and precedes dual input.
- R9: Opcode 0x02 produces count SCK periods without touching either data FIFO and with io_oe_o = 00.
- R10: An input operation with a count above 256 transfers exactly 256 bytes. A count of 0 on a shifting or idle opcode produces no SCK pulse.
- R11: The engine holds SCK low and does not advance in two cases: when a byte to send is needed and the write FIFO is empty, and when an input byte would start while the read FIFO is full. It resumes without losing or repeating data.
- R12: Each SCK high phase lasts exactly HALF_DIV system clocks.
- R13: The flags irq_o[5:0] are sticky and have the following meanings: 0 operation push while full, 1 operation FIFO empty while chip select is low and the engine waits for a word, 2 write push while full, 3 engine starved of a write byte, 4 engine blocked by a full read FIFO, 5 read pop while empty. A flag sets only when its enable bit in irq_en_i is 1. Writing 1 to a bit of irq_clr_i clears that flag.
- R14: An opcode outside the listed set is consumed with no effect on the pins or the FIFOs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_push_i | input | 1 | Push an operation word |
| op_data_i | input | 14 | Operation word (opcode 13:9, count 8:0) |
| op_full_o | output | 1 | Operation FIFO full |
| op_empty_o | output | 1 | Operation FIFO empty |
| wr_push_i | input | 1 | Push a byte to send |
| wr_data_i | input | 8 | Byte to send |
| wr_full_o | output | 1 | Write FIFO full |
| wr_empty_o | output | 1 | Write FIFO empty |
| rd_pop_i | input | 1 | Pop the head received byte |
| rd_data_o | output | 8 | Head of the read FIFO |
| rd_full_o | output | 1 | Read FIFO full |
| rd_empty_o | output | 1 | Read FIFO empty |
| irq_en_i | input | 6 | Per-flag enable |
| irq_clr_i | input | 6 | Write-1 clear of flags |
| irq_o | output | 6 | Sticky interrupt flags |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| io_o | output | 2 | Data line outputs (IO1, IO0) |
| io_oe_o | output | 2 | Data line output enables |
| io_i | input | 2 | Data line inputs (IO1, IO0) |

## Verification
Several properties are checked on every cycle. The data lines and their enables must hold steady while SCK is high. Chip select may move only with SCK low. The enable pair never takes the value 10. Every SCK high phase lasts exactly the programmed number of clocks. No flag rises without its enable. The bench scenarios cover the remaining behaviours: bit ordering and lane mapping in each shift mode, line release after the turnaround opcodes, the 256-byte input cap, stalls against empty and full FIFOs with correct resumption, and the effect of each individual flag.

// File: rtl/spi_uop_pkg.sv
package spi_uop_pkg;
  localparam int OPW  = 14;
  localparam int CNTW = 9;
  localparam logic [CNTW-1:0] IN_CAP = 9'd256;

  localparam logic [4:0] UOP_CS_HI   = 5'h00;
  localparam logic [4:0] UOP_CS_LO   = 5'h01;
  localparam logic [4:0] UOP_IDLE    = 5'h02;
  localparam logic [4:0] UOP_OUT1    = 5'h08;
  localparam logic [4:0] UOP_OUT2    = 5'h09;
  localparam logic [4:0] UOP_IN1     = 5'h0C;
  localparam logic [4:0] UOP_IN2     = 5'h0E;
  localparam logic [4:0] UOP_TA_1TO1 = 5'h10;
  localparam logic [4:0] UOP_TA_1TO2 = 5'h11;
  localparam logic [4:0] UOP_TA_2TO2 = 5'h14;

  typedef enum logic [1:0] {ST_FETCH, ST_LOAD, ST_LOW, ST_HIGH} st_e;

  typedef struct packed {
    logic shift;    // op uses the bit engine
    logic is_in;
    logic dual;
    logic idle;
    logic rel_end;  // release lines when op ends
  } mode_t;

  function automatic mode_t uop_decode(logic [4:0] opc);
    mode_t m;
    m = '0;
    case (opc)
      UOP_IDLE:    begin m.shift = 1'b1; m.idle = 1'b1; end
      UOP_OUT1:    m.shift = 1'b1;
      UOP_OUT2:    begin m.shift = 1'b1; m.dual = 1'b1; end
      UOP_IN1:     begin m.shift = 1'b1; m.is_in = 1'b1; end
      UOP_IN2:     begin m.shift = 1'b1; m.is_in = 1'b1; m.dual = 1'b1; end
      UOP_TA_1TO1,
      UOP_TA_1TO2: begin m.shift = 1'b1; m.rel_end = 1'b1; end
      UOP_TA_2TO2: begin m.shift = 1'b1; m.dual = 1'b1; m.rel_end = 1'b1; end
      default:     m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/spi_uop_fifo.sv
module spi_uop_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW:0]      wp_q, rp_q;
  logic             do_push, do_pop;

  assign full_o  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign empty_o = (wp_q == rp_q);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q[AW-1:0]] <= wdata_i;
  end
endmodule

// File: rtl/spi_uop_irq.sv
module spi_uop_irq #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 f_q <= 1'b0;
      else if (ev_i[k] && en_i[k]) f_q <= 1'b1;  // set wins over clear
      else if (clr_i[k])           f_q <= 1'b0;
    end
    assign flag_o[k] = f_q;
  end
endmodule

// File: rtl/spi_uop_engine.sv
module spi_uop_engine
  import spi_uop_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           op_valid_i,
  input  logic [OPW-1:0] op_word_i,
  output logic           op_pop_o,
  input  logic           wr_valid_i,
  input  logic [7:0]     wr_byte_i,
  output logic           wr_pop_o,
  input  logic           rd_ready_i,
  output logic           rd_push_o,
  output logic [7:0]     rd_byte_o,
  output logic           op_starve_o,
  output logic           wr_starve_o,
  output logic           rd_block_o,
  output logic           sck_o,
  output logic           cs_no,
  output logic [1:0]     io_o,
  output logic [1:0]     io_oe_o,
  input  logic [1:0]     io_i
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  st_e             st_q;
  mode_t           mode_q, f_mode;
  logic [CNTW-1:0] units_q, f_units, f_cnt;
  logic [4:0]      f_opc;
  logic [3:0]      bits_q;
  logic [CW-1:0]   cnt_q;
  logic [7:0]      sh_q;
  logic            sck_q, cs_q;
  logic [1:0]      oe_q;
  logic            half_done, is_out;

  assign f_opc   = op_word_i[OPW-1:CNTW];
  assign f_cnt   = op_word_i[CNTW-1:0];
  assign f_mode  = uop_decode(f_opc);
  assign f_units = (f_mode.is_in && f_cnt > IN_CAP) ? IN_CAP : f_cnt;

  assign half_done = (cnt_q == CNT_LAST);
  assign is_out    = !mode_q.is_in && !mode_q.idle;

  assign op_pop_o    = (st_q == ST_FETCH) && op_valid_i;
  assign wr_pop_o    = (st_q == ST_LOAD) && is_out && wr_valid_i;
  assign rd_push_o   = (st_q == ST_HIGH) && half_done && mode_q.is_in && (bits_q == 4'd1);
  assign rd_byte_o   = sh_q;
  assign op_starve_o = (st_q == ST_FETCH) && !op_valid_i && !cs_q;
  assign wr_starve_o = (st_q == ST_LOAD) && is_out && !wr_valid_i;
  assign rd_block_o  = (st_q == ST_LOAD) && mode_q.is_in && !rd_ready_i;

  assign sck_o   = sck_q;
  assign cs_no   = cs_q;
  assign io_oe_o = oe_q;
  assign io_o    = !is_out ? 2'b00 : (mode_q.dual ? sh_q[7:6] : {1'b0, sh_q[7]});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_FETCH;
      mode_q  <= '0;
      units_q <= '0;
      bits_q  <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      oe_q    <= 2'b00;
    end else begin
      case (st_q)
        ST_FETCH: begin
          if (op_valid_i) begin
            if (f_opc == UOP_CS_HI) begin
              cs_q <= 1'b1;
              oe_q <= 2'b00;
            end else if (f_opc == UOP_CS_LO) begin
              cs_q <= 1'b0;
            end else if (f_mode.shift) begin
              mode_q  <= f_mode;
              units_q <= f_units;
              if (f_mode.is_in || f_mode.idle) oe_q <= 2'b00;
              if (f_cnt == '0) begin
                if (f_mode.rel_end) oe_q <= 2'b00;
              end else begin
                st_q <= ST_LOAD;
              end
            end
          end
        end
        ST_LOAD: begin
          cnt_q <= '0;
          if (mode_q.idle) begin
            bits_q <= 4'd1;
            st_q   <= ST_LOW;
          end else if (mode_q.is_in) begin
            if (rd_ready_i) begin
              bits_q <= mode_q.dual ? 4'd4 : 4'd8;
              sh_q   <= '0;
              st_q   <= ST_LOW;
            end
          end else if (wr_valid_i) begin
            sh_q   <= wr_byte_i;
            oe_q   <= mode_q.dual ? 2'b11 : 2'b01;
            bits_q <= mode_q.dual ? 4'd4 : 4'd8;
            st_q   <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (half_done) begin
            cnt_q <= '0;
            sck_q <= 1'b1;
            st_q  <= ST_HIGH;
            if (mode_q.is_in)
              sh_q <= mode_q.dual ? {sh_q[5:0], io_i} : {sh_q[6:0], io_i[1]};
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HIGH: begin
          if (half_done) begin
            cnt_q  <= '0;
            sck_q  <= 1'b0;
            bits_q <= bits_q - 1'b1;
            if (is_out) sh_q <= mode_q.dual ? {sh_q[5:0], 2'b00} : {sh_q[6:0], 1'b0};
            if (bits_q == 4'd1) begin
              units_q <= units_q - 1'b1;
              if (units_q == 9'd1) begin
                st_q <= ST_FETCH;
                if (mode_q.rel_end) oe_q <= 2'b00;
              end else begin
                st_q <= ST_LOAD;
              end
            end else begin
              st_q <= ST_LOW;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/spi_uop_seq.sv
module spi_uop_seq
  import spi_uop_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int OP_DEPTH = 4,
  parameter int WR_DEPTH = 4,
  parameter int RD_DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        op_push_i,
  input  logic [13:0] op_data_i,
  output logic        op_full_o,
  output logic        op_empty_o,
  input  logic        wr_push_i,
  input  logic [7:0]  wr_data_i,
  output logic        wr_full_o,
  output logic        wr_empty_o,
  input  logic        rd_pop_i,
  output logic [7:0]  rd_data_o,
  output logic        rd_full_o,
  output logic        rd_empty_o,
  input  logic [5:0]  irq_en_i,
  input  logic [5:0]  irq_clr_i,
  output logic [5:0]  irq_o,
  output logic        sck_o,
  output logic        cs_no,
  output logic [1:0]  io_o,
  output logic [1:0]  io_oe_o,
  input  logic [1:0]  io_i
);
  logic [OPW-1:0] op_word;
  logic           op_pop, wr_pop, rd_push;
  logic [7:0]     wr_byte, rd_byte;
  logic           op_starve, wr_starve, rd_block;
  logic [5:0]     irq_ev;

  spi_uop_fifo #(.WIDTH(OPW), .DEPTH(OP_DEPTH)) u_op_fifo (
    .clk_i, .rst_ni, .push_i(op_push_i), .wdata_i(op_data_i), .pop_i(op_pop),
    .rdata_o(op_word), .full_o(op_full_o), .empty_o(op_empty_o));

  spi_uop_fifo #(.WIDTH(8), .DEPTH(WR_DEPTH)) u_wr_fifo (
    .clk_i, .rst_ni, .push_i(wr_push_i), .wdata_i(wr_data_i), .pop_i(wr_pop),
    .rdata_o(wr_byte), .full_o(wr_full_o), .empty_o(wr_empty_o));

  spi_uop_fifo #(.WIDTH(8), .DEPTH(RD_DEPTH)) u_rd_fifo (
    .clk_i, .rst_ni, .push_i(rd_push), .wdata_i(rd_byte), .pop_i(rd_pop_i),
    .rdata_o(rd_data_o), .full_o(rd_full_o), .empty_o(rd_empty_o));

  spi_uop_engine #(.HALF_DIV(HALF_DIV)) u_engine (
    .clk_i, .rst_ni,
    .op_valid_i(!op_empty_o), .op_word_i(op_word), .op_pop_o(op_pop),
    .wr_valid_i(!wr_empty_o), .wr_byte_i(wr_byte), .wr_pop_o(wr_pop),
    .rd_ready_i(!rd_full_o), .rd_push_o(rd_push), .rd_byte_o(rd_byte),
    .op_starve_o(op_starve), .wr_starve_o(wr_starve), .rd_block_o(rd_block),
    .sck_o, .cs_no, .io_o, .io_oe_o, .io_i);

  assign irq_ev = {rd_pop_i && rd_empty_o,
                   rd_block,
                   wr_starve,
                   wr_push_i && wr_full_o,
                   op_starve,
                   op_push_i && op_full_o};

  spi_uop_irq #(.N(6)) u_irq (
    .clk_i, .rst_ni, .ev_i(irq_ev), .en_i(irq_en_i), .clr_i(irq_clr_i), .flag_o(irq_o));
endmodule

// File: rtl/spi_uop_seq_chk.sv
module spi_uop_seq_chk #(
  parameter int HALF_DIV = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sck_o,
  input logic       cs_no,
  input logic [1:0] io_o,
  input logic [1:0] io_oe_o,
  input logic [5:0] irq_en_i,
  input logic [5:0] irq_o
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_cnt <= '0;
    else if (!sck_o) hi_cnt <= '0;
    else             hi_cnt <= hi_cnt + 1'b1;
  end

  a_r3_lines_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> ($stable(io_o) && $stable(io_oe_o)));

  a_r1_cs_moves_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cs_no) |-> !sck_o);

  a_r5_oe_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o != 2'b10);

  a_r12_high_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sck_o) |-> (hi_cnt == 16'(HALF_DIV)));

  for (genvar k = 0; k < 6; k++) begin : g_irq
    a_r13_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[k]) |-> $past(irq_en_i[k]));
  end
endmodule

bind spi_uop_seq spi_uop_seq_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sck_o(sck_o), .cs_no(cs_no), .io_o(io_o),
  .io_oe_o(io_oe_o), .irq_en_i(irq_en_i), .irq_o(irq_o));

// File: tb/spi_uop_seq_tb.sv
`timescale 1ns/1ps
module spi_uop_seq_tb;
  localparam int HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic op_push = 0, wr_push = 0, rd_pop = 0;
  logic [13:0] op_data = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic op_full, op_empty, wr_full, wr_empty, rd_full, rd_empty;
  logic [5:0] irq_en = '0, irq_clr = '0, irq;
  logic sck, cs_n;
  logic [1:0] io_out, io_oe, io_in;

  spi_uop_seq #(.HALF_DIV(HALF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_push_i(op_push), .op_data_i(op_data),
    .op_full_o(op_full), .op_empty_o(op_empty), .wr_push_i(wr_push), .wr_data_i(wr_data),
    .wr_full_o(wr_full), .wr_empty_o(wr_empty), .rd_pop_i(rd_pop), .rd_data_o(rd_data),
    .rd_full_o(rd_full), .rd_empty_o(rd_empty), .irq_en_i(irq_en), .irq_clr_i(irq_clr),
    .irq_o(irq), .sck_o(sck), .cs_no(cs_n), .io_o(io_out), .io_oe_o(io_oe), .io_i(io_in));

  // flash model: records driven bits, supplies bits when lines released
  int rises = 0, rx_bits = 0, idx = 0, in_base = 0;
  logic [31:0] rx = '0;
  logic [7:0] in_byte = '0, cur;
  logic slv_dual = 0;
  always @(posedge sck) begin
    rises = rises + 1;
    if (!cs_n) begin
      if (io_oe == 2'b11)      begin rx = {rx[29:0], io_out}; rx_bits = rx_bits + 2; end
      else if (io_oe == 2'b01) begin rx = {rx[30:0], io_out[0]}; rx_bits = rx_bits + 1; end
      else idx = idx + (slv_dual ? 2 : 1);
    end
  end
  assign cur   = in_byte << ((idx - in_base) % 8);
  assign io_in = slv_dual ? cur[7:6] : {cur[7], 1'b0};

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_op(input logic [4:0] opc, input int cnt);
    @(negedge clk); op_push = 1; op_data = {opc, 9'(cnt)};
    @(negedge clk); op_push = 0;
  endtask

  task automatic push_wr(input logic [7:0] b);
    @(negedge clk); wr_push = 1; wr_data = b;
    @(negedge clk); wr_push = 0;
  endtask

  task automatic pulse_clr(input logic [5:0] m);
    @(negedge clk); irq_clr = m;
    @(negedge clk); irq_clr = '0;
  endtask

  // drain read FIFO for n cycles, returns bytes popped and mismatches vs exp
  task automatic drain(input int n, input logic [7:0] exp, output int got, output int bad);
    got = 0; bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (rd_pop) rd_pop = 0;
      else if (!rd_empty) begin
        got++;
        if (rd_data != exp) bad++;
        rd_pop = 1;
      end
    end
    @(negedge clk); rd_pop = 0;
  endtask

  // vector: opcode, byte supplied, byte expected, io_oe after op
  localparam logic [22:0] VEC [8] = '{
    {5'h08, 8'hA5, 8'hA5, 2'b01},
    {5'h09, 8'h3C, 8'h3C, 2'b11},
    {5'h10, 8'h96, 8'h96, 2'b00},
    {5'h11, 8'h5A, 8'h5A, 2'b00},
    {5'h14, 8'hC3, 8'hC3, 2'b00},
    {5'h0C, 8'h81, 8'h81, 2'b00},
    {5'h0E, 8'hE7, 8'hE7, 2'b00},
    {5'h08, 8'h01, 8'h01, 2'b01}
  };

  initial begin
    int r0, base, got, bad, hw, g;
    cyc(3); rst_n = 1; cyc(2);
    // R2 reset state
    chk(cs_n == 1 && sck == 0 && io_oe == 2'b00, "R2 pins", {cs_n, sck, io_oe}, 4'b1000);
    chk(irq == 0, "R2 flags", irq, 0);
    chk(op_empty && wr_empty && rd_empty, "R2 fifos", {op_empty, wr_empty, rd_empty}, 3'b111);

    push_op(5'h01, 1); cyc(3);
    chk(cs_n == 0, "R1 cs low", cs_n, 0);

    for (int i = 0; i < 8; i++) begin
      logic [4:0] opc; logic [7:0] tx, ex; logic [1:0] oe_x;
      {opc, tx, ex, oe_x} = VEC[i];
      if (opc == 5'h0C || opc == 5'h0E) begin  // R6 R7
        slv_dual = (opc == 5'h0E); in_byte = tx; in_base = idx;
        push_op(opc, 1);
        g = 0;
        while (rd_empty && g < 500) begin @(negedge clk); g++; end
        chk(rd_data == ex, "R6/R7 input byte", rd_data, ex);
        @(negedge clk); rd_pop = 1; @(negedge clk); rd_pop = 0;
      end else begin  // R4 R5 R8
        base = rx_bits; slv_dual = 0;
        push_wr(tx); push_op(opc, 1);
        g = 0;
        while (rx_bits < base + 8 && g < 500) begin @(negedge clk); g++; end
        cyc(8);
        chk(rx[7:0] == ex, "R4/R5/R8 output byte", rx[7:0], ex);
      end
      chk(io_oe == oe_x, "R8 line enables after op", io_oe, oe_x);
    end

    push_op(5'h00, 1); cyc(3);
    chk(cs_n == 1 && io_oe == 2'b00, "R1 cs high releases", {cs_n, io_oe}, 3'b100);

    // R9 idle clocks
    push_wr(8'h77); r0 = rises;
    push_op(5'h02, 5); cyc(60);
    chk(rises - r0 == 5, "R9 idle periods", rises - r0, 5);
    chk(wr_empty == 0 && io_oe == 2'b00, "R9 no fifo use", {wr_empty, io_oe}, 0);
    push_op(5'h08, 1); cyc(60);
    chk(wr_empty == 1, "R9 byte kept for later op", wr_empty, 1);

    // R10 zero count
    r0 = rises; push_op(5'h0C, 0); cyc(20);
    chk(rises == r0 && rd_empty, "R10 zero count", rises - r0, 0);

    // R10 cap at 256
    push_op(5'h01, 1); slv_dual = 0; in_byte = 8'hB4; in_base = idx; r0 = rises;
    push_op(5'h0C, 9'h1FF);
    drain(12000, 8'hB4, got, bad);
    chk(got == 256, "R10 capped byte count", got, 256);
    chk(bad == 0, "R10 capped data", bad, 0);
    chk(rises - r0 == 2048, "R10 capped clocks", rises - r0, 2048);
    push_op(5'h00, 1);

    // R11 write stall, R13 flag 3
    irq_en = 6'b001000;
    push_op(5'h01, 1); base = rx_bits;
    push_op(5'h08, 2); push_wr(8'hE1); cyc(200);
    chk(rx_bits - base == 8, "R11 stall after first byte", rx_bits - base, 8);
    chk(sck == 0, "R11 sck low in stall", sck, 0);
    chk(irq[3] == 1, "R13 write starve flag", irq[3], 1);
    push_wr(8'h4D); cyc(100);
    chk(rx_bits - base == 16 && rx[7:0] == 8'h4D, "R11 resume write", rx[7:0], 8'h4D);
    push_op(5'h00, 1); irq_en = 0; pulse_clr(6'h3F);
    chk(irq == 0, "R13 clear", irq, 0);

    // R11 read stall, R13 flag 4
    irq_en = 6'b010000;
    push_op(5'h01, 1); in_byte = 8'h5F; in_base = idx; slv_dual = 0; r0 = rises;
    push_op(5'h0C, 6); cyc(400);
    chk(rd_full == 1 && rises - r0 == 32, "R11 read stall", rises - r0, 32);
    chk(irq[4] == 1, "R13 read block flag", irq[4], 1);
    drain(600, 8'h5F, got, bad);
    chk(got == 6 && bad == 0 && rises - r0 == 48, "R11 resume read", got, 6);
    push_op(5'h00, 1); irq_en = 0; pulse_clr(6'h3F);

    // R12 high phase width
    push_wr(8'hFF); push_op(5'h08, 1);
    g = 0;
    while (!sck && g < 100) begin @(negedge clk); g++; end
    hw = 0;
    while (sck && hw < 100) begin @(negedge clk); hw++; end
    chk(hw == HALF, "R12 high width", hw, HALF);
    cyc(60);

    // R13 op overflow set, write overflow masked
    irq_en = 6'b000001;
    push_op(5'h02, 511); cyc(5);
    for (int k = 0; k < 5; k++) push_op(5'h02, 0);
    chk(irq[0] == 1, "R13 op overflow", irq[0], 1);
    for (int k = 0; k < 5; k++) push_wr(8'h00);
    chk(irq[2] == 0 && wr_full == 1, "R13 masked write overflow", irq[2], 0);
    irq_en = 0; cyc(3000);
    push_op(5'h08, 4); cyc(200);
    chk(wr_empty == 1, "R13 drain", wr_empty, 1);
    pulse_clr(6'h3F);

    // R13 read underflow and clear
    irq_en = 6'b100000;
    @(negedge clk); rd_pop = 1; @(negedge clk); rd_pop = 0;
    chk(irq[5] == 1, "R13 read underflow", irq[5], 1);
    irq_en = 0; pulse_clr(6'b100000);
    chk(irq[5] == 0, "R13 write-1 clear", irq[5], 0);

    // R13 op starve
    irq_en = 6'b000010;
    push_op(5'h01, 1); cyc(10);
    chk(irq[1] == 1, "R13 op starve", irq[1], 1);
    irq_en = 0; push_op(5'h00, 1); pulse_clr(6'h3F);

    // R14 unknown opcode
    push_wr(8'h11); r0 = rises;
    push_op(5'h1F, 3); cyc(40);
    chk(rises == r0 && cs_n == 1 && wr_empty == 0, "R14 unknown no effect", rises - r0, 0);
    push_op(5'h01, 1); cyc(5);
    chk(cs_n == 0, "R14 next op runs", cs_n, 0);
    push_op(5'h00, 1); push_op(5'h08, 1); cyc(60);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule